// File: doc/BRIEF.md
# Configurable Nine-Bit UART Transmitter

This block serializes characters onto an asynchronous serial line. It takes one byte at a time through a valid/ready handshake and builds a frame from it. The frame is a low start bit, the eight data bits sent least significant first, up to two extra bits and one or two high stop bits. When the line is idle it sits high. The bit rate comes from a tick enable supplied by the surrounding logic, and each bit lasts a fixed number of those ticks.

A set of static mode inputs picks the frame layout. Eight-bit mode can append a parity bit. Nine-bit mode appends a ninth bit. That bit is either a value held in a software-written register, which is useful as a repeated address mark, or generated parity. Extended nine-bit mode sends the register bit and then a parity bit computed over all nine data bits, giving a 12-bit frame with one stop bit. Some mode combinations are not allowed. The block samples the modes when it accepts a byte, and if the combination is not allowed it drops the byte, leaves the line idle and raises an error flag.

Top module: `uart9_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `in_ready` is 1 and `cfg_err` is 0. While `busy` is 0, `txd` is 1.
- R2: With `mode_nine`=0, a frame is: a start bit of 0, then `in_data` bit 0 through bit 7, then a parity bit only if `par_en`=1, then the stop bits of 1.
- R3: With `mode_nine`=1, `mode_ext`=0 and `par_en`=0, the bit after data bit 7 is the ninth-bit register value, which makes an 11-bit frame with one stop bit.
- R4: With `mode_nine`=1, `mode_ext`=0 and `par_en`=1, the bit after data bit 7 is the parity over the eight data bits and not the register value.
- R5: With `mode_nine`=1, `mode_ext`=1 and `par_en`=1, the frame is the start bit, the 8 data bits, the register bit, then the parity over those nine data bits, then the stop bits. With one stop bit this is 12 bits.
- R6: Parity makes the count of ones over the data bits and the parity bit even when `par_odd`=0, and odd when `par_odd`=1.
- R7: With `two_stop`=1, the frame ends with two stop bits instead of one.
- R8: The ninth-bit register loads `bit9_val` only in a cycle with `bit9_wr`=1. Every later frame reuses the stored value until the next write.
- R9: Each bit is held on `txd` for 16 cycles in which `baud_tick` is 1. Cycles without a tick do not advance the frame.
- R10: A handshake with `mode_ext`=1 together with `par_en`=0 or `mode_nine`=0 sends nothing and sets `cfg_err`. In that case `txd` stays 1 and `busy` stays 0. `cfg_err` keeps its value until the next accepted handshake, which rewrites it.
- R11: `in_ready` is the inverse of `busy`. A handshake with a valid mode sets `busy` in the next cycle. While a frame is being sent, changes to `in_valid` and `in_data` have no effect on it. `busy` falls at the end of the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Baud rate enable, one per tick |
| mode_nine | input | 1 | Selects nine-bit character mode |
| mode_ext | input | 1 | Selects the extended 12-bit frame in nine-bit mode |
| par_en | input | 1 | Enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 sends two stop bits |
| bit9_wr | input | 1 | Write strobe for the ninth-bit register |
| bit9_val | input | 1 | Value written to the ninth-bit register |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte to transmit |
| in_ready | output | 1 | The block can accept a byte |
| txd | output | 1 | Serial line output, idles high |
| busy | output | 1 | A frame is being transmitted |
| cfg_err | output | 1 | The last accepted handshake had an invalid mode |

## Verification
The hardest case to reach from the ports is the split between the register bit and generated parity in the ninth position. The register is sticky, so a stale value would look correct whenever it happens to equal the parity. For this reason the stimulus sweeps all 32 mode combinations for both register values and for several data bytes. After each register write it also drives the opposite value on `bit9_val` without the strobe. The bench also offers a new byte while a frame is in flight, and it repeats one frame with a slower tick to separate tick counting from clock counting.

// File: rtl/uart9_pkg.sv
// Shared types for the nine-bit UART transmitter.
// Assumes the mode fields are static for the duration of one handshake.
package uart9_pkg;
    typedef struct packed {
        logic nine;      // nine-bit character mode
        logic ext;       // extended frame: register bit plus parity
        logic par_en;    // parity bit enabled
        logic par_odd;   // odd parity when set
        logic two_stop;  // two stop bits when set
    } uart9_mode_t;

    // Mode combinations the transmitter refuses to start.
    function automatic logic uart9_mode_bad(uart9_mode_t m);
        return m.ext && (!m.par_en || !m.nine);
    endfunction
endpackage

// File: rtl/uart9_frame_build.sv
// Builds the transmit frame, LSB first, from the byte, the mode and the ninth-bit value.
// Unused upper positions are filled with 1, so the stop bits come for free.
// Assumes the mode is valid; invalid modes are never loaded by the caller.
module uart9_frame_build
    import uart9_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 5,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  uart9_mode_t        mode,
    input  logic [DATA_W-1:0]  data,
    input  logic               ninth,
    output logic [FRAME_W-1:0] vec,
    output logic [CNT_W-1:0]   nbits
);
    logic par_byte;
    logic par_nine;

    // Parity bits for the two data lengths, with the polarity applied.
    always_comb begin
        par_byte = (^data) ^ mode.par_odd;
        par_nine = par_byte ^ ninth;
    end

    // Frame assembly: start, data, optional extra bits, stop bits of 1.
    always_comb begin
        int pos;
        vec = '1;
        vec[0] = 1'b0;
        vec[DATA_W:1] = data;
        pos = DATA_W + 1;
        if (mode.nine && mode.ext) begin
            vec[pos]     = ninth;
            vec[pos + 1] = par_nine;
            pos = pos + 2;
        end else if (mode.nine && !mode.par_en) begin
            vec[pos] = ninth;
            pos = pos + 1;
        end else if (mode.par_en) begin
            vec[pos] = par_byte;
            pos = pos + 1;
        end
        nbits = CNT_W'(pos + 1 + int'(mode.two_stop));
    end
endmodule

// File: rtl/uart9_bit_timer.sv
// Counts baud ticks and pulses bit_end on the last tick of each bit period.
// Assumes clear is pulsed when a frame is loaded, so every frame starts on a full bit.
module uart9_bit_timer #(
    parameter int TICKS = 16,
    parameter int CW    = (TICKS > 1) ? $clog2(TICKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    logic [CW-1:0] cnt_q;

    // End of a bit period: the last tick while a frame is running.
    always_comb bit_end = run && tick && (cnt_q == CW'(TICKS - 1));

    // Tick counter, restarted on a frame load and after each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart9_shift_reg.sv
// Holds the frame and shifts it out LSB first, one bit per advance pulse.
// It counts the bits that remain and drops busy after the last stop bit.
// Assumes load is asserted only while busy is low.
module uart9_shift_reg #(
    parameter int FRAME_W = 13,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] vec,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               advance,
    output logic               busy,
    output logic               line
);
    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   left_q;
    logic               busy_q;

    // Frame register, remaining-bit count and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '1;
            left_q <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            sr_q   <= vec;
            left_q <= nbits;
            busy_q <= 1'b1;
        end else if (advance && busy_q) begin
            sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1))
                busy_q <= 1'b0;
        end
    end

    // The line follows the frame head while busy and idles high otherwise.
    always_comb begin
        busy = busy_q;
        line = busy_q ? sr_q[0] : 1'b1;
    end
endmodule

// File: rtl/uart9_tx.sv
// Nine-bit capable UART transmitter top.
// Accepts a byte on a valid/ready handshake and samples the mode inputs on that cycle.
// It either refuses the frame, flagging cfg_err, or loads and serializes it.
// Assumes baud_tick is a single-cycle enable at 16 times the bit rate.
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    localparam int FRAME_W      = DATA_W + 5,
    localparam int CNT_W        = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              mode_nine,
    input  logic              mode_ext,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              bit9_wr,
    input  logic              bit9_val,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              busy,
    output logic              cfg_err
);
    uart9_mode_t        mode;
    logic               accept;
    logic               bad;
    logic               load;
    logic               ninth_q;
    logic               err_q;
    logic               bit_end;
    logic [FRAME_W-1:0] vec;
    logic [CNT_W-1:0]   nbits;

    // Gather the mode inputs and decode the handshake.
    always_comb begin
        mode     = '{nine: mode_nine, ext: mode_ext, par_en: par_en,
                     par_odd: par_odd, two_stop: two_stop};
        bad      = uart9_mode_bad(mode);
        in_ready = !busy;
        accept   = in_valid && in_ready;
        load     = accept && !bad;
        cfg_err  = err_q;
    end

    // Sticky ninth-bit register, written only by its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ninth_q <= 1'b0;
        else if (bit9_wr)
            ninth_q <= bit9_val;
    end

    // Error flag, rewritten on every accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (accept)
            err_q <= bad;
    end

    uart9_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) build_i (
        .mode  (mode),
        .data  (in_data),
        .ninth (ninth_q),
        .vec   (vec),
        .nbits (nbits)
    );

    uart9_bit_timer #(.TICKS(TICKS_PER_BIT)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .run     (busy),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    uart9_shift_reg #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .vec     (vec),
        .nbits   (nbits),
        .advance (bit_end),
        .busy    (busy),
        .line    (txd)
    );
endmodule

// File: rtl/uart9_tx_checker.sv
// Protocol checker for uart9_tx, attached by bind. It decodes invalid modes on its own.
module uart9_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic mode_nine,
    input logic mode_ext,
    input logic par_en,
    input logic bit9_wr,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy,
    input logic cfg_err,
    input logic ninth_q
);
    logic inval;
    always_comb inval = mode_ext && !(par_en && mode_nine);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    assert_last_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));
    assert_ninth_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit9_wr |=> $stable(ninth_q));
    assert_no_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(txd));
    assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && inval) |=> (!busy && cfg_err));
    assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !inval) |=> (busy && !cfg_err));
    assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);
endmodule

bind uart9_tx uart9_tx_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .mode_nine (mode_nine),
    .mode_ext  (mode_ext),
    .par_en    (par_en),
    .bit9_wr   (bit9_wr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .txd       (txd),
    .busy      (busy),
    .cfg_err   (cfg_err),
    .ninth_q   (ninth_q)
);

// File: tb/uart9_tx_tb_top.sv
// Sweep bench for uart9_tx: every mode, both ninth-bit values, several bytes, and a slow tick.
module uart9_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       mode_nine = 1'b0, mode_ext = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       bit9_wr = 1'b0, bit9_val = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, txd, busy, cfg_err;

    int checks = 0;
    int errors = 0;
    int div = 1;
    int tcnt = 0;

    always #2 clk = ~clk;

    uart9_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .mode_nine(mode_nine), .mode_ext(mode_ext), .par_en(par_en),
        .par_odd(par_odd), .two_stop(two_stop),
        .bit9_wr(bit9_wr), .bit9_val(bit9_val),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .txd(txd), .busy(busy), .cfg_err(cfg_err)
    );

    // Tick generator: one tick every div cycles, driven away from the active edge.
    always @(negedge clk) begin
        tcnt <= (tcnt + 1 >= div) ? 0 : tcnt + 1;
        baud_tick <= (div == 1) ? 1'b1 : (tcnt == 0);
    end

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic write_ninth(input logic v);
        @(negedge clk);
        bit9_wr = 1'b1; bit9_val = v;
        @(negedge clk);
        bit9_wr = 1'b0; bit9_val = ~v;  // R8: opposite value without the strobe
    endtask

    // Sends one byte and checks every bit, or the refusal for an invalid mode.
    task automatic send(input logic [7:0] d, input logic [4:0] m, input logic b9);
        logic [15:0] ev;
        int          n;
        int          ones;
        string       tag [16];
        bit          bad;
        mode_nine = m[0]; mode_ext = m[1]; par_en = m[2]; par_odd = m[3]; two_stop = m[4];
        bad = m[1] && (!m[2] || !m[0]);
        ones = $countones(d);
        ev = '1; ev[0] = 1'b0; tag[0] = "R2";
        for (int i = 0; i < 8; i++) begin ev[i+1] = d[i]; tag[i+1] = "R2"; end
        n = 9;
        if (m[0] && m[1]) begin
            ev[9] = b9; tag[9] = "R5";
            ev[10] = logic'(((ones + int'(b9)) % 2) != 0) ^ m[3]; tag[10] = "R6";
            n = 11;
        end else if (m[0] && !m[2]) begin
            ev[9] = b9; tag[9] = "R3"; n = 10;
        end else if (m[2]) begin
            ev[9] = logic'((ones % 2) != 0) ^ m[3]; tag[9] = m[0] ? "R4" : "R6"; n = 10;
        end
        for (int i = n; i < 16; i++) tag[i] = "R7";
        n = n + 1 + int'(m[4]);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        if (bad) begin
            check("R10", cfg_err, 1, "cfg_err after invalid mode");
            for (int c = 0; c < 20; c++) begin
                check("R10", {busy, txd}, 1, "line idle after refusal");
                @(negedge clk);
            end
            return;
        end
        check("R11", cfg_err, 0, "cfg_err after valid mode");
        check("R11", in_ready, 0, "in_ready while sending");
        repeat (8 * div) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            check(tag[k], txd, ev[k], $sformatf("bit %0d mode %0d data %0h", k, m, d));
            if (k == 1) begin in_valid = 1'b1; in_data = ~d; end  // R11: ignored offer
            if (k == 3) in_valid = 1'b0;
            if (k < n - 1) repeat (16 * div) @(negedge clk);
        end
        if (div == 1) begin
            repeat (7) @(negedge clk);
            check("R11", busy, 1, "busy in last cycle of frame");
            @(negedge clk);
            check("R9", busy, 0, "busy after 16 ticks per bit");
        end else begin
            repeat (8 * div + 2) @(negedge clk);
            check("R9", busy, 0, "busy after slow-tick frame");
        end
        check("R1", txd, 1, "idle line after frame");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", txd, 1, "txd after reset");
        check("R1", busy, 0, "busy after reset");
        check("R1", in_ready, 1, "in_ready after reset");
        check("R1", cfg_err, 0, "cfg_err after reset");
        for (int b = 0; b < 2; b++) begin
            write_ninth(logic'(b));
            for (int m = 0; m < 32; m++) begin
                send(8'hA5, 5'(m), logic'(b));
                send(8'h01, 5'(m), logic'(b));
                send(8'hFF, 5'(m), logic'(b));
            end
        end
        // R10: the error flag holds until the next accepted handshake.
        send(8'h3C, 5'b00010, 1'b1);
        repeat (30) @(negedge clk);
        check("R10", cfg_err, 1, "cfg_err held while idle");
        // R9: slow tick, one tick every three cycles.
        div = 3;
        send(8'h96, 5'b00111, 1'b1);
        div = 1;
        repeat (4) @(negedge clk);
        send(8'h5A, 5'b10101, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule